// File: doc/BRIEF.md
# MII Link Duplex Resolver

This block keeps a MAC's operating mode in step with what an attached Ethernet PHY has negotiated. Each poll strobe starts one poll, which issues register reads through an external MDIO master. The poll reads the PHY status register (1) and then the link-partner ability register (5). The block first checks whether a PHY answers at all and whether the link is up. It then masks the partner's abilities with the local advertisement and works out duplex and speed from the bits that remain.

The result lands in a mode word. One bit of that word selects full duplex and another selects the transmit threshold. The threshold bit is set for 10 Mb/s operation and cleared when a 100 Mb/s mode is shared. When the new word differs from the stored one, the block stores it and pulses a restart request so that the MAC restarts its receive and transmit engines. Every poll ends with a one-cycle done pulse, and a changed flag comes with that pulse only when the word moved. MDIO frame generation and the MAC datapath lie outside this block.

Top module: `mii_duplex_resolver`

## Requirements
- R1: After reset the mode word equals MODE_RESET (default 0), link-ok, PHY-missing, done, changed and restart are all 0, and no MDIO read is requested.
- R2: A poll reads register 1 before register 5. A read holds `mdio_req_o` high with a stable `mdio_reg_o` until the cycle in which `mdio_done_i` is high, and `mdio_data_i` is taken in that cycle.
- R3: A status value of 16'hFFFF ends the poll. PHY-missing becomes 1 and link-ok becomes 0, register 5 is not read, and the mode word is unchanged with no changed pulse.
- R4: If status bit 2 (link) reads 0, register 1 is read once more. If the second reading also has bit 2 clear, link-ok becomes 0 and PHY-missing 0, register 5 is not read, and the mode word is unchanged.
- R5: If the second status reading has bit 2 set, the poll goes on to read register 5 as if the link had been up from the start.
- R6: The common ability is the register-5 value ANDed with the local advertisement. The transmit-threshold bit (bit THR_BIT, default 22) is cleared when any common bit 7, 8 or 9 is set, and is set otherwise.
- R7: The full-duplex bit (bit 9, value 0x0200) is 1 in three cases: when the duplex lock is high, when common bit 8 is set, or when common bits 8:6 equal 3'b001. Otherwise it is 0. In particular, 100 half together with 10 full resolves to half duplex.
- R8: After a register-5 read, a candidate word that differs from the stored one is stored. It comes with one-cycle `changed_o` and `restart_o` pulses in the same cycle as `done_o`. An equal candidate leaves the word unchanged and gives no pulse. The mode word changes at no other time.
- R9: A poll strobe that arrives while a poll is in progress is ignored: it causes no extra reads and no extra done pulse.
- R10: Each poll ends with exactly one single-cycle `done_o` pulse. Link-ok becomes 1 and PHY-missing 0 whenever register 5 was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Start a poll (taken when idle) |
| adv_i | input | 16 | Local advertisement value |
| dup_lock_i | input | 1 | Force full duplex |
| mdio_req_o | output | 1 | Read request to the MDIO master |
| mdio_reg_o | output | 5 | PHY register number to read |
| mdio_done_i | input | 1 | Read complete, data valid |
| mdio_data_i | input | 16 | Read data |
| mode_o | output | MODE_W | MAC mode word |
| link_ok_o | output | 1 | Link was up at the last completed poll |
| phy_missing_o | output | 1 | Last poll found no PHY |
| done_o | output | 1 | Poll finished (one cycle) |
| changed_o | output | 1 | Mode word changed at this poll end |
| restart_o | output | 1 | Receive/transmit restart request |

## Verification
The assertions check the cycle-level handshake rules on every cycle. They confirm that requests hold steady and only name registers 1 and 5, that changed and restart come paired with done, that the mode word moves only on a changed pulse, and that link-ok and PHY-missing are never both set. The bench's scenarios are the only thing that can show the number and order of reads in a poll. That covers the single re-read after a latched-low link, the skipped partner read when no PHY answers and the strobe ignored while busy. They also cover the duplex and threshold values resolved from each ability mix, including 100 half combined with 10 full and a forced duplex lock.

// File: rtl/mldr_pkg.sv
package mldr_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_STATUS  = 2'd1,
      SEQ_PARTNER = 2'd2
   } seq_state_t;

   localparam logic [4:0]  REG_STATUS   = 5'd1;
   localparam logic [4:0]  REG_PARTNER  = 5'd5;
   localparam int          LINK_BIT     = 2;
   localparam logic [15:0] ABSENT_VALUE = 16'hFFFF;
endpackage

// File: rtl/mldr_ability_resolve.sv
module mldr_ability_resolve #(
   parameter int ADV_W = 16
) (
   input  logic [ADV_W-1:0] partner_i,
   input  logic [ADV_W-1:0] adv_i,
   input  logic             lock_i,
   output logic             full_dup_o,
   output logic             fast_o
);
   logic [ADV_W-1:0] common;

   always_comb begin
      common     = partner_i & adv_i;
      fast_o     = |common[9:7];
      full_dup_o = lock_i | common[8] | (common[8:6] == 3'b001);
   end
endmodule

// File: rtl/mldr_mode_reg.sv
module mldr_mode_reg #(
   parameter int               MODE_W     = 32,
   parameter int               THR_BIT    = 22,
   parameter int               FD_BIT     = 9,
   parameter logic [MODE_W-1:0] MODE_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic              full_dup_i,
   input  logic              fast_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              changed_o,
   output logic              restart_o
);
   logic [MODE_W-1:0] cand;

   always_comb begin
      cand          = mode_o;
      cand[FD_BIT]  = full_dup_i;
      cand[THR_BIT] = ~fast_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o    <= MODE_RESET;
         changed_o <= 1'b0;
         restart_o <= 1'b0;
      end else begin
         changed_o <= 1'b0;
         restart_o <= 1'b0;
         if (upd_i && (cand != mode_o)) begin
            mode_o    <= cand;
            changed_o <= 1'b1;
            restart_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mldr_poll_seq.sv
module mldr_poll_seq
   import mldr_pkg::*;
#(
   parameter int ADV_W       = 16,
   parameter bit CAPTURE_ADV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll_i,
   input  logic [ADV_W-1:0] adv_i,
   input  logic             mdio_done_i,
   input  logic [15:0]      mdio_data_i,
   output logic             mdio_req_o,
   output logic [4:0]       mdio_reg_o,
   output logic [ADV_W-1:0] adv_use_o,
   output logic             upd_o,
   output logic             link_ok_o,
   output logic             phy_missing_o,
   output logic             done_o
);
   seq_state_t state;
   logic       retry_q;
   logic       start;

   assign start      = (state == SEQ_IDLE) && poll_i;
   assign mdio_req_o = (state != SEQ_IDLE);
   assign mdio_reg_o = (state == SEQ_PARTNER) ? REG_PARTNER : REG_STATUS;
   assign upd_o      = (state == SEQ_PARTNER) && mdio_done_i;

   generate
      if (CAPTURE_ADV) begin : g_adv_hold
         logic [ADV_W-1:0] adv_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     adv_q <= '0;
            else if (start) adv_q <= adv_i;
         end
         assign adv_use_o = adv_q;
      end else begin : g_adv_live
         assign adv_use_o = adv_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= SEQ_IDLE;
         retry_q       <= 1'b0;
         link_ok_o     <= 1'b0;
         phy_missing_o <= 1'b0;
         done_o        <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state   <= SEQ_STATUS;
                  retry_q <= 1'b0;
               end
            end
            SEQ_STATUS: begin
               if (mdio_done_i) begin
                  if (mdio_data_i == ABSENT_VALUE) begin
                     phy_missing_o <= 1'b1;
                     link_ok_o     <= 1'b0;
                     done_o        <= 1'b1;
                     state         <= SEQ_IDLE;
                  end else if (!mdio_data_i[LINK_BIT]) begin
                     if (retry_q) begin
                        phy_missing_o <= 1'b0;
                        link_ok_o     <= 1'b0;
                        done_o        <= 1'b1;
                        state         <= SEQ_IDLE;
                     end else begin
                        retry_q <= 1'b1;
                     end
                  end else begin
                     state <= SEQ_PARTNER;
                  end
               end
            end
            SEQ_PARTNER: begin
               if (mdio_done_i) begin
                  phy_missing_o <= 1'b0;
                  link_ok_o     <= 1'b1;
                  done_o        <= 1'b1;
                  state         <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mii_duplex_resolver.sv
module mii_duplex_resolver #(
   parameter int                MODE_W      = 32,
   parameter int                THR_BIT     = 22,
   parameter logic [MODE_W-1:0] MODE_RESET  = '0,
   parameter bit                CAPTURE_ADV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_i,
   input  logic [15:0]       adv_i,
   input  logic              dup_lock_i,
   output logic              mdio_req_o,
   output logic [4:0]        mdio_reg_o,
   input  logic              mdio_done_i,
   input  logic [15:0]       mdio_data_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              link_ok_o,
   output logic              phy_missing_o,
   output logic              done_o,
   output logic              changed_o,
   output logic              restart_o
);
   localparam int ADV_W  = 16;
   localparam int FD_BIT = 9;

   initial begin
      assert (MODE_W > FD_BIT) else $error("MODE_W too small for duplex bit");
      assert (THR_BIT < MODE_W) else $error("THR_BIT outside mode word");
      assert (THR_BIT != FD_BIT) else $error("THR_BIT overlaps duplex bit");
   end

   logic [ADV_W-1:0] adv_use;
   logic             upd;
   logic             full_dup;
   logic             fast;

   mldr_poll_seq #(.ADV_W(ADV_W), .CAPTURE_ADV(CAPTURE_ADV)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .poll_i        (poll_i),
      .adv_i         (adv_i),
      .mdio_done_i   (mdio_done_i),
      .mdio_data_i   (mdio_data_i),
      .mdio_req_o    (mdio_req_o),
      .mdio_reg_o    (mdio_reg_o),
      .adv_use_o     (adv_use),
      .upd_o         (upd),
      .link_ok_o     (link_ok_o),
      .phy_missing_o (phy_missing_o),
      .done_o        (done_o)
   );

   mldr_ability_resolve #(.ADV_W(ADV_W)) u_res (
      .partner_i  (mdio_data_i),
      .adv_i      (adv_use),
      .lock_i     (dup_lock_i),
      .full_dup_o (full_dup),
      .fast_o     (fast)
   );

   mldr_mode_reg #(
      .MODE_W(MODE_W), .THR_BIT(THR_BIT), .FD_BIT(FD_BIT), .MODE_RESET(MODE_RESET)
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_i      (upd),
      .full_dup_i (full_dup),
      .fast_i     (fast),
      .mode_o     (mode_o),
      .changed_o  (changed_o),
      .restart_o  (restart_o)
   );
endmodule

// File: rtl/mldr_checker.sv
module mldr_checker #(
   parameter int MODE_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdio_req_o,
   input logic [4:0]        mdio_reg_o,
   input logic              mdio_done_i,
   input logic [MODE_W-1:0] mode_o,
   input logic              link_ok_o,
   input logic              phy_missing_o,
   input logic              done_o,
   input logic              changed_o,
   input logic              restart_o
);
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req_o && !mdio_done_i) |=> (mdio_req_o && $stable(mdio_reg_o)));

   p_reg_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req_o |-> (mdio_reg_o == 5'd1 || mdio_reg_o == 5'd5));

   p_missing_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phy_missing_o |-> !link_ok_o);

   p_change_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      changed_o |-> (done_o && restart_o && link_ok_o));

   p_restart_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> changed_o);

   p_mode_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_o) |-> changed_o);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind mii_duplex_resolver mldr_checker #(.MODE_W(MODE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mdio_req_o    (mdio_req_o),
   .mdio_reg_o    (mdio_reg_o),
   .mdio_done_i   (mdio_done_i),
   .mode_o        (mode_o),
   .link_ok_o     (link_ok_o),
   .phy_missing_o (phy_missing_o),
   .done_o        (done_o),
   .changed_o     (changed_o),
   .restart_o     (restart_o)
);

// File: tb/mii_duplex_resolver_tb.sv
module mii_duplex_resolver_tb_top;
   localparam int MODE_W = 32;
   localparam int THR    = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic poll_i = 1'b0;
   logic [15:0] adv_i = '0;
   logic dup_lock_i = 1'b0;
   logic mdio_req_o;
   logic [4:0] mdio_reg_o;
   logic mdio_done_i = 1'b0;
   logic [15:0] mdio_data_i = '0;
   logic [MODE_W-1:0] mode_o;
   logic link_ok_o, phy_missing_o, done_o, changed_o, restart_o;

   always #2 clk = ~clk;

   mii_duplex_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .adv_i(adv_i),
      .dup_lock_i(dup_lock_i), .mdio_req_o(mdio_req_o), .mdio_reg_o(mdio_reg_o),
      .mdio_done_i(mdio_done_i), .mdio_data_i(mdio_data_i), .mode_o(mode_o),
      .link_ok_o(link_ok_o), .phy_missing_o(phy_missing_o), .done_o(done_o),
      .changed_o(changed_o), .restart_o(restart_o)
   );

   typedef struct {
      string             tag;
      logic              missing;
      logic              link;
      logic [MODE_W-1:0] mode;
      logic              changed;
      int                n_stat;
      int                n_part;
   } exp_t;

   exp_t exp_q[$];
   int compared = 0;
   int mismatched = 0;
   int polls_done = 0;
   bit finished = 0;

   logic [15:0] phy_stat1, phy_stat2, phy_part;
   int n_stat = 0, n_part = 0;
   bit order_bad = 0;
   logic [MODE_W-1:0] exp_mode = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // PHY model behind the MDIO master
   initial begin
      forever begin
         @(negedge clk);
         if (mdio_req_o) begin
            repeat (2) @(negedge clk);
            if (mdio_reg_o == 5'd1) begin
               mdio_data_i = (n_stat == 0) ? phy_stat1 : phy_stat2;
               if (n_part != 0) order_bad = 1;
               n_stat++;
            end else begin
               mdio_data_i = phy_part;
               n_part++;
            end
            mdio_done_i = 1'b1;
            @(negedge clk);
            mdio_done_i = 1'b0;
         end
      end
   end

   // Monitor: pops the expectation at each poll end
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done_o) begin
            exp_t e;
            polls_done++;
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected done", 32'd1, 32'd0);
            end else begin
               e = exp_q.pop_front();
               chk(phy_missing_o == e.missing, {e.tag, " missing"}, phy_missing_o, e.missing);
               chk(link_ok_o == e.link, {e.tag, " link_ok"}, link_ok_o, e.link);
               chk(mode_o == e.mode, {e.tag, " mode"}, mode_o, e.mode);
               chk(changed_o == e.changed, {e.tag, " changed"}, changed_o, e.changed);
               chk(restart_o == e.changed, {e.tag, " restart"}, restart_o, e.changed);
               chk(n_stat == e.n_stat, {e.tag, " R2 status reads"}, n_stat, e.n_stat);
               chk(n_part == e.n_part, {e.tag, " R2 partner reads"}, n_part, e.n_part);
               chk(!order_bad, {e.tag, " R2 read order"}, order_bad, 0);
            end
         end else if (rst_n && (changed_o || restart_o)) begin
            chk(0, "R8 pulse without done", {changed_o, restart_o}, 0);
         end
      end
   end

   // Driver: computes the expectation from the requirements, then polls
   task automatic do_poll(input string tag, input logic [15:0] s1, input logic [15:0] s2,
                          input logic [15:0] part, input logic [15:0] adv,
                          input logic lock, input bit extra);
      exp_t e;
      logic [15:0] c;
      logic fd, fast;
      logic [MODE_W-1:0] cand;
      e.tag = tag;
      e.changed = 0;
      e.n_part = 0;
      if (s1 == 16'hFFFF) begin                       // R3
         e.missing = 1; e.link = 0; e.n_stat = 1;
      end else if (!s1[2] && (s2 == 16'hFFFF)) begin   // R3 on re-read
         e.missing = 1; e.link = 0; e.n_stat = 2;
      end else if (!s1[2] && !s2[2]) begin             // R4
         e.missing = 0; e.link = 0; e.n_stat = 2;
      end else begin                                   // R5, R6, R7
         e.missing = 0; e.link = 1; e.n_part = 1;
         e.n_stat = s1[2] ? 1 : 2;
         c = part & adv;
         fast = (c & 16'h0380) != 0;
         fd = lock | c[8] | (c[8:6] == 3'b001);
         cand = exp_mode;
         cand[9] = fd;
         cand[THR] = ~fast;
         if (cand != exp_mode) begin
            e.changed = 1;
            exp_mode = cand;
         end
      end
      e.mode = exp_mode;
      exp_q.push_back(e);
      phy_stat1 = s1; phy_stat2 = s2; phy_part = part;
      n_stat = 0; n_part = 0; order_bad = 0;
      adv_i = adv; dup_lock_i = lock;
      @(negedge clk);
      poll_i = 1'b1;
      @(negedge clk);
      poll_i = 1'b0;
      if (extra) begin
         @(negedge clk);
         poll_i = 1'b1;                                // R9: strobe while busy
         @(negedge clk);
         poll_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mode_o == '0, "R1 mode", mode_o, 0);
      chk(!link_ok_o && !phy_missing_o, "R1 flags", {link_ok_o, phy_missing_o}, 0);
      chk(!done_o && !changed_o && !restart_o, "R1 pulses", {done_o, changed_o, restart_o}, 0);
      chk(!mdio_req_o, "R1 no request", mdio_req_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_poll("R3 absent",          16'hFFFF, 16'hFFFF, 16'h01E1, 16'h01E1, 0, 0);
      do_poll("R6 R7 R8 100full",   16'h782D, 16'h782D, 16'h01E1, 16'h01E1, 0, 0);
      do_poll("R8 no change",       16'h782D, 16'h782D, 16'h01E1, 16'h01E1, 0, 0);
      do_poll("R4 link down",       16'h7809, 16'h7809, 16'h01E1, 16'h01E1, 0, 0);
      do_poll("R5 R6 relatched",    16'h7809, 16'h782D, 16'h0021, 16'h01E1, 0, 0);
      do_poll("R7 10full only",     16'h782D, 16'h782D, 16'h0041, 16'h01E1, 0, 0);
      do_poll("R7 lock forces fd",  16'h782D, 16'h782D, 16'h0021, 16'h01E1, 1, 0);
      do_poll("R6 R7 adv mask",     16'h782D, 16'h782D, 16'h01E1, 16'h0081, 0, 0);
      do_poll("R9 busy strobe",     16'h782D, 16'h782D, 16'h01E1, 16'h0081, 0, 1);
      do_poll("R7 100half 10full",  16'h782D, 16'h782D, 16'h00C1, 16'h01E1, 0, 0);
      do_poll("R3 absent on reread",16'h7809, 16'hFFFF, 16'h01E1, 16'h01E1, 0, 0);
      do_poll("R10 recover",        16'h782D, 16'h782D, 16'h0041, 16'h01E1, 0, 0);

      chk(polls_done == 12, "R10 one done per poll", polls_done, 12);
      chk(exp_q.size() == 0, "R10 all polls ended", exp_q.size(), 0);
      finished = 1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         @(negedge clk);
         chk(0, "R10 watchdog expired", 0, 1);
         summary();
      end
   end
endmodule